// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for a processor that keeps its translations in a three-level page table with 8 KiB pages. Each request carries the address, the kind of access (read, write, execute, or a probe that checks no rights) and whether the requester runs in kernel or user mode. Before touching memory, the block checks that the address is canonical. It also recognises a direct-mapped kernel window, which it translates without reading any table.

All other addresses are resolved by reading one table entry per level through a single 64-bit read port. That port has one read in flight at a time and a latency that may vary. The leaf entry supplies the physical frame and the read and write enables for each mode. It also carries fault-on-read, fault-on-write and fault-on-execute bits, which take rights away again. The block answers with the physical address and the rights it grants. On a failure it returns a fault code, the faulting virtual address and the reported access type instead. Caching of translations is left to the surrounding logic.

Top module: `ptw3`

## Requirements
- R1: A virtual address whose bits 63 down to 43 are not all equal is rejected with a fault of code 1 (access violation), and no table read is made.
- R2: A canonical address with bit 63 set and bits 42:41 equal to binary 10 is the kernel window. In kernel mode it succeeds without any table read, with physical address equal to the low 40 address bits and rights 3'b111 (bit 0 read, bit 1 write, bit 2 execute). In user mode it faults with code 1.
- R3: The walk reads the entry at base + index*8. The level-1 base comes from `ptbase`, and each later base is entry bits 63:32 shifted left by 13. The level-1, level-2 and level-3 indices are address bits 42:33, 32:23 and 22:13.
- R4: At level 1 or 2, an entry with bit 0 (valid) clear faults with code 0 (translation not valid). An entry with bit 8 (kernel read) clear faults with code 1. In both cases the walk makes no further read.
- R5: A level-3 entry with bit 0 clear faults with code 0.
- R6: At the leaf, entry bit 8 (kernel) or bit 9 (user) grants read and execute, and entry bit 12 (kernel) or bit 13 (user) grants write. For a read, write or execute access that was not granted, the block faults with code 1.
- R7: Granted read, write and execute are then removed by entry bits 1, 2 and 3. If the needed right is gone, the block faults with code 3 (execute), 4 (write) or 2 (read). On success the reported rights are the rights that remain.
- R8: A probe (access code 3) never faults on leaf rights. It returns either the translation with the remaining rights or a code 0 fault.
- R9: A successful walk returns the physical address {entry[63:32], vaddr[12:0]}, zero-extended.
- R10: Every response returns the request's virtual address. It also reports the access type, where the request codes read 0, write 1, exec 2 and probe 3 are reported as 00, 01, 11 and 10. A faulting response reports rights 000.
- R11: A request is taken only while `req_ready` is high, which is only when no request is in progress. A memory read stays asserted with a stable address until it is accepted. A response stays valid and stable until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access: 0 read, 1 write, 2 exec, 3 probe |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| ptbase | input | 64 | Level-1 table base address |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Table entry |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Result consumed |
| rsp_fault | output | 1 | Translation failed |
| rsp_code | output | 3 | Fault code |
| rsp_paddr | output | 64 | Physical address |
| rsp_prot | output | 3 | Granted rights: bit0 read, bit1 write, bit2 exec |
| rsp_vaddr | output | 64 | Request virtual address |
| rsp_acc | output | 2 | Reported access type |

## Verification
The enable check and the fault-on masking are evaluated on the same leaf entry in the same cycle. When an entry both lacks a right and sets the matching fault-on bit, the access-violation code has to win. The bench sweeps all 128 combinations of the seven leaf control bits in both modes and for all four access kinds. It compares each result against a code and rights value that it derives arithmetically from the requirements, which makes every such collision occur. A second collision occurs between the canonical check and the kernel-window decode of the same address. This is provoked with non-canonical addresses whose bits 42:41 are 10, which must report code 1 and make no read.

// File: rtl/ptw3.sv
module ptw3 #(
  parameter int PG_BITS  = 13,
  parameter int IDX_BITS = 10,
  parameter int SP_BITS  = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_vaddr,
  input  logic [1:0]  req_acc,
  input  logic        req_user,
  input  logic [63:0] ptbase,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_fault,
  output logic [2:0]  rsp_code,
  output logic [63:0] rsp_paddr,
  output logic [2:0]  rsp_prot,
  output logic [63:0] rsp_vaddr,
  output logic [1:0]  rsp_acc
);
  localparam int VA_BITS = PG_BITS + 3 * IDX_BITS;
  localparam logic [2:0] C_TNV = 3'd0, C_ACV = 3'd1, C_FOR = 3'd2, C_FOE = 3'd3, C_FOW = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WT, S_DONE} state_t;
  state_t      state;
  logic [1:0]  lvl, acc;
  logic        user;
  logic [63:0] va, base;

  logic [63-VA_BITS:0] hi;
  logic                canon, sp;
  assign hi    = req_vaddr[63:VA_BITS];
  assign canon = (&hi) | ~(|hi);
  assign sp    = req_vaddr[63] && (req_vaddr[VA_BITS-1 -: 2] == 2'b10);

  logic [IDX_BITS-1:0] idx;
  always_comb
    case (lvl)
      2'd0:    idx = va[PG_BITS + 2*IDX_BITS +: IDX_BITS];
      2'd1:    idx = va[PG_BITS + IDX_BITS +: IDX_BITS];
      default: idx = va[PG_BITS +: IDX_BITS];
    endcase

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_RD);
  assign mem_req_addr  = base + {{(61-IDX_BITS){1'b0}}, idx, 3'b000};
  assign rsp_valid     = (state == S_DONE);
  assign rsp_vaddr     = va;
  assign rsp_acc       = (acc == 2'd2) ? 2'b11 : (acc == 2'd3) ? 2'b10 : acc;

  logic [2:0] need, grant, masked, fo_code;
  logic       rd_en, wr_en, leaf_acv, leaf_fo;
  assign need     = (acc == 2'd0) ? 3'b001 : (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b100 : 3'b000;
  assign rd_en    = user ? mem_rsp_data[9]  : mem_rsp_data[8];
  assign wr_en    = user ? mem_rsp_data[13] : mem_rsp_data[12];
  assign grant    = {rd_en, wr_en, rd_en};
  assign masked   = grant & ~mem_rsp_data[3:1];
  assign leaf_acv = (|need) && !(|(grant & need));
  assign leaf_fo  = (|need) && !(|(masked & need));
  assign fo_code  = need[2] ? C_FOE : need[1] ? C_FOW : C_FOR;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; lvl <= 2'd0; acc <= 2'd0; user <= 1'b0;
      va <= '0; base <= '0;
      rsp_fault <= 1'b0; rsp_code <= C_TNV; rsp_paddr <= '0; rsp_prot <= 3'b000;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va <= req_vaddr; acc <= req_acc; user <= req_user; base <= ptbase; lvl <= 2'd0;
          if (!canon || (sp && req_user)) begin
            state <= S_DONE; rsp_fault <= 1'b1; rsp_code <= C_ACV;
            rsp_paddr <= '0; rsp_prot <= 3'b000;
          end else if (sp) begin
            state <= S_DONE; rsp_fault <= 1'b0; rsp_code <= C_TNV;
            rsp_paddr <= 64'(req_vaddr[SP_BITS-1:0]); rsp_prot <= 3'b111;
          end else
            state <= S_RD;
        end
        S_RD: if (mem_req_ready) state <= S_WT;
        S_WT: if (mem_rsp_valid) begin
          state <= S_DONE; rsp_fault <= 1'b1; rsp_paddr <= '0; rsp_prot <= 3'b000;
          if (!mem_rsp_data[0])
            rsp_code <= C_TNV;
          else if (lvl != 2'd2) begin
            if (!mem_rsp_data[8])
              rsp_code <= C_ACV;
            else begin
              state     <= S_RD;
              rsp_fault <= 1'b0;
              base      <= 64'(mem_rsp_data[63:32]) << PG_BITS;
              lvl       <= lvl + 2'd1;
            end
          end else if (leaf_acv)
            rsp_code <= C_ACV;
          else if (leaf_fo)
            rsp_code <= fo_code;
          else begin
            rsp_fault <= 1'b0; rsp_code <= C_TNV;
            rsp_paddr <= 64'({mem_rsp_data[63:32], va[PG_BITS-1:0]});
            rsp_prot  <= masked;
          end
        end
        default: if (rsp_ready) state <= S_IDLE;
      endcase
    end

  AST_NONCANON_ACV: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !canon |=> rsp_valid && rsp_fault && rsp_code == 3'd1); // R1
  AST_KSEG_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && canon && sp && !req_user |=> rsp_valid && !rsp_fault && rsp_prot == 3'b111); // R2
  AST_PROBE_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_acc == 2'b10 && rsp_fault |-> rsp_code <= 3'd1); // R8
  AST_FAULT_NO_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_prot == 3'b000); // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_paddr) && $stable(rsp_fault)); // R11
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || rsp_valid) |-> !req_ready); // R11
endmodule

// File: tb/sim_ptw3.sv
module sim_ptw3;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic        req_valid = 1'b0, req_user = 1'b0, mem_req_ready = 1'b1;
  logic        mem_rsp_valid = 1'b0, rsp_ready = 1'b0;
  logic [1:0]  req_acc = 2'd0;
  logic [63:0] req_vaddr = '0, mem_rsp_data = '0;
  logic [63:0] ptbase = 64'h0000_0000_0100_0000;
  logic        req_ready, mem_req_valid, rsp_valid, rsp_fault;
  logic [63:0] mem_req_addr, rsp_paddr, rsp_vaddr;
  logic [2:0]  rsp_code, rsp_prot;
  logic [1:0]  rsp_acc;

  ptw3 u0 (.*);

  int tests = 0, fails = 0;
  logic [63:0] pte [3];
  logic [63:0] ea  [3];
  int          rd_idx = 0, nreq = 0, cnt = 0;
  logic        e_fault;
  logic [2:0]  e_code, e_prot;
  logic [63:0] e_paddr;
  int          e_nrd;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pte[rd_idx];
        rd_idx++;
      end
    end else if (mem_req_valid) begin
      chk(rd_idx < 3 && mem_req_addr == ea[rd_idx], "R3 entry address", mem_req_addr, ea[rd_idx % 3]);
      nreq++;
      cnt = 1 + (nreq % 3);
    end
  end

  task automatic model(logic [63:0] va, logic [1:0] acc, logic usr);
    logic [2:0] need, g, mk;
    logic r, w;
    e_fault = 1'b1; e_code = 3'd1; e_prot = 3'b000; e_paddr = '0; e_nrd = 0;
    if (!((&va[63:43]) || !(|va[63:43]))) return;
    if (va[63] && va[42:41] == 2'b10) begin
      if (!usr) begin
        e_fault = 1'b0; e_code = 3'd0; e_prot = 3'b111; e_paddr = va & ((64'd1 << 40) - 1);
      end
      return;
    end
    ea[0] = ptbase + 64'(va[42:33]) * 8;
    ea[1] = (64'(pte[0][63:32]) << 13) + 64'(va[32:23]) * 8;
    ea[2] = (64'(pte[1][63:32]) << 13) + 64'(va[22:13]) * 8;
    for (int l = 0; l < 2; l++) begin
      e_nrd = l + 1;
      if (!pte[l][0]) begin e_code = 3'd0; return; end
      if (!pte[l][8]) begin e_code = 3'd1; return; end
    end
    e_nrd = 3;
    if (!pte[2][0]) begin e_code = 3'd0; return; end
    need = (acc == 0) ? 3'd1 : (acc == 1) ? 3'd2 : (acc == 2) ? 3'd4 : 3'd0;
    r = pte[2][8 + int'(usr)];
    w = pte[2][12 + int'(usr)];
    g = {r, w, r};
    mk = g & ~pte[2][3:1];
    if (need != 0 && (g & need) == 0) begin e_code = 3'd1; return; end
    if (need != 0 && (mk & need) == 0) begin
      e_code = (need == 4) ? 3'd3 : (need == 2) ? 3'd4 : 3'd2;
      return;
    end
    e_fault = 1'b0; e_code = 3'd0; e_prot = mk;
    e_paddr = 64'({pte[2][63:32], va[12:0]});
  endtask

  task automatic run(logic [63:0] va, logic [1:0] acc, logic usr, string tag);
    logic [2:0]  c0;
    logic [63:0] p0;
    logic [1:0]  eacc;
    model(va, acc, usr);
    eacc = (acc == 2) ? 2'b11 : (acc == 3) ? 2'b10 : acc;
    rd_idx = 0;
    @(negedge clk);
    chk(req_ready, "R11 ready when idle", 64'(req_ready), 64'd1);
    req_vaddr = va; req_acc = acc; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    c0 = rsp_code; p0 = rsp_paddr;
    @(negedge clk);
    chk(rsp_valid && rsp_code == c0 && rsp_paddr == p0, "R11 response held", {c0, p0[60:0]}, {rsp_code, rsp_paddr[60:0]});
    chk(rsp_fault == e_fault, {tag, " fault flag"}, 64'(rsp_fault), 64'(e_fault));
    if (e_fault) chk(rsp_code == e_code, {tag, " code"}, 64'(rsp_code), 64'(e_code));
    else chk(rsp_paddr == e_paddr, {tag, " R9 paddr"}, rsp_paddr, e_paddr);
    chk(rsp_prot == e_prot, {tag, " R10 prot"}, 64'(rsp_prot), 64'(e_prot));
    chk(rsp_vaddr == va && rsp_acc == eacc, "R10 vaddr/acc report", {rsp_vaddr[61:0], rsp_acc}, {va[61:0], eacc});
    chk(rd_idx == e_nrd, {tag, " read count"}, 64'(rd_idx), 64'(e_nrd));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] va;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !mem_req_valid && req_ready, "R11 reset state",
        {61'd0, rsp_valid, mem_req_valid, req_ready}, 64'd1);
    rst_n = 1'b1;
    pte[0] = 64'h0000_0123_0000_0101;
    pte[1] = 64'h0000_0456_0000_0101;

    for (int m = 0; m < 128; m++)
      for (int u = 0; u < 2; u++)
        for (int a = 0; a < 4; a++) begin
          pte[2] = {32'h0007_0000 + 32'(m * 7), 32'd1};
          pte[2][1] = m[0]; pte[2][2] = m[1]; pte[2][3] = m[2];
          pte[2][8] = m[3]; pte[2][9] = m[4]; pte[2][12] = m[5]; pte[2][13] = m[6];
          va = (64'(m) * 64'h0000_009E_3779_B97F + 64'(u * 13 + a)) & ((64'd1 << 43) - 1);
          run(va, 2'(a), u[0], "R6 R7 R8 leaf");
        end

    pte[2] = 64'h0000_0999_0000_330E;
    for (int a = 0; a < 4; a++) run(64'h0000_0012_3456_7000, 2'(a), 1'b0, "R5 leaf invalid");

    pte[2] = 64'h0000_0999_0000_3301;
    for (int l = 0; l < 2; l++) begin
      pte[l] = 64'h0000_0777_0000_0100;
      run(64'h0000_0400_0000_2000, 2'd0, 1'b0, "R4 upper invalid");
      run(64'h0000_0400_0000_2000, 2'd3, 1'b0, "R4 R8 upper invalid probe");
      pte[l] = 64'h0000_0777_0000_3201;
      run(64'h0000_07FF_FFFF_E000, 2'd1, 1'b1, "R4 upper no kernel read");
      pte[l] = (l == 0) ? 64'h0000_0123_0000_0101 : 64'h0000_0456_0000_0101;
    end

    run(64'h0000_0800_0000_0000, 2'd0, 1'b0, "R1 noncanonical");
    run(64'h8000_0400_0000_0000, 2'd3, 1'b0, "R1 noncanonical probe");
    run(64'hFFFF_F400_0000_0000, 2'd2, 1'b0, "R1 noncanonical kseg bits");
    run(64'h7FFF_FFFF_FFFF_FFFF, 2'd1, 1'b1, "R1 noncanonical high");
    run(64'h0000_07FF_FFFF_F123, 2'd0, 1'b0, "R1 R3 top canonical positive");
    run(64'hFFFF_FC12_3456_789A, 2'd1, 1'b0, "R2 kseg kernel");
    run(64'hFFFF_FDFF_FFFF_FFFF, 2'd2, 1'b0, "R2 kseg kernel top");
    run(64'hFFFF_FC00_0000_0000, 2'd3, 1'b0, "R2 kseg probe");
    run(64'hFFFF_FC12_3456_789A, 2'd0, 1'b1, "R2 kseg user");
    run(64'hFFFF_FE00_0000_4000, 2'd0, 1'b0, "R2 R3 negative walk");
    run(64'hFFFF_F800_0000_4000, 2'd1, 1'b1, "R2 R3 negative walk low");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule